// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a PS/2 keyboard byte receiver and turns the raw byte stream of the power-up default scan code set into clean key events. Each event carries a key code, a flag for keys that use the extended prefix, and a flag that marks a key release. Prefix bytes are absorbed into a small amount of state. The fake shift sequences that the keyboard puts around extended keys while shift or num-lock is active are dropped, so they do not appear as key events.

The block also keeps a table of the keys that are currently held down. Plain codes and extended codes each have their own bit per code. A press sets the bit and a release clears it, so overlapping keystrokes are tracked correctly. Any entry can be read at any time through a combinational query port. A consumer such as a game controller or a key-matrix model can act on the event strobe, or poll the table for the state of several keys at once.

Top module: `kbd_event_decoder`

## Requirements
- R1: After reset, `evt_vld` is 0 and the query port reports every one of the 512 table entries (both banks, all codes) as not held.
- R2: A byte other than 0xE0 or 0xF0, received with no prefix pending, produces a one-cycle event on the cycle after it is accepted, with `evt_code` equal to the byte, `evt_ext`=0 and `evt_rel`=0.
- R3: The byte 0xF0 produces no event by itself. The next non-prefix byte produces an event with `evt_rel`=1 and that byte as the code.
- R4: The byte 0xE0 produces no event by itself. The next non-prefix byte produces an event with `evt_ext`=1. The sequence 0xE0 0xF0 code gives `evt_ext`=1 and `evt_rel`=1.
- R5: When the extended prefix is pending, a byte of 0x12 ends the sequence with no event and no change to the held table, with or without a pending 0xF0. This covers the wrapper sequences E0 12 and E0 F0 12.
- R6: A press event sets the table entry addressed by (extended flag, code). A release event clears it. The plain bank (`qry_ext`=0) and the extended bank (`qry_ext`=1) are independent. The table changes on the same clock edge that raises the event.
- R7: Several keys can be held at the same time. Releasing one of them leaves the others marked held.
- R8: A release of a key that is not marked held still produces a release event, and it leaves every table entry unchanged.
- R9: The pending prefix state clears whenever a non-prefix byte completes a sequence, whether an event is emitted or the byte is discarded. The next byte is decoded with no prefix pending.
- R10: Bytes are taken only on cycles with `byte_vld`=1. Idle cycles between the bytes of a sequence do not change the result, and `evt_vld` is high for exactly one cycle per emitted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| evt_vld | output | 1 | Key event strobe, one cycle |
| evt_code | output | 8 | Key code of the event |
| evt_ext | output | 1 | Event is for an extended key |
| evt_rel | output | 1 | Event is a release (0 = press) |
| qry_ext | input | 1 | Query bank select: 1 = extended codes |
| qry_code | input | 8 | Query key code |
| qry_held | output | 1 | Selected key is currently held |

## Verification
The main sweep walks every one of the 256 code values through four shapes: a plain press, an extended press, a plain release and an extended release. This shows that the two prefixes set separate flags and that the two banks of the table do not alias each other. Separate patterns handle the rest. Wrapper sequences are placed around a held plain shift key, which tells a discarded wrapper apart from a real shift release. Overlapping presses followed by a partial release check that the table holds several keys at once. A release of a key that was never pressed is also sent. Idle gaps are inserted inside prefix sequences, which shows that the decoder counts accepted bytes and not clock cycles.

// File: rtl/kbd_dec_pkg.sv
package kbd_dec_pkg;
  localparam int unsigned KC_W = 8;

  typedef struct packed {
    logic            vld;
    logic            ext;
    logic            rel;
    logic [KC_W-1:0] code;
  } kbd_evt_t;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/kbd_prefix_fsm.sv
module kbd_prefix_fsm
  import kbd_dec_pkg::*;
#(
  parameter logic [KC_W-1:0] EXT_PREFIX = 8'hE0,
  parameter logic [KC_W-1:0] REL_PREFIX = 8'hF0,
  parameter logic [KC_W-1:0] SHIFT_CODE = 8'h12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_vld,
  input  logic [KC_W-1:0] byte_data,
  output logic            ext_pend,
  output logic            rel_pend,
  output kbd_evt_t        evt_now,
  output kbd_evt_t        evt_q
);
  logic     ext_q, rel_q, ext_d, rel_d;
  logic     is_ext_pfx, is_rel_pfx, is_wrapper;
  kbd_evt_t evt_d;

  assign is_ext_pfx = (byte_data == EXT_PREFIX);
  assign is_rel_pfx = (byte_data == REL_PREFIX);
  assign is_wrapper = ext_q && (byte_data == SHIFT_CODE);

  always_comb begin
    ext_d = ext_q;
    rel_d = rel_q;
    evt_d = '0;
    if (is_ext_pfx) begin
      ext_d = 1'b1;
    end else if (is_rel_pfx) begin
      rel_d = 1'b1;
    end else begin
      ext_d = 1'b0;
      rel_d = 1'b0;
      if (!is_wrapper) begin
        evt_d.vld  = 1'b1;
        evt_d.ext  = ext_q;
        evt_d.rel  = rel_q;
        evt_d.code = byte_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      rel_q <= 1'b0;
    end else if (byte_vld) begin
      ext_q <= ext_d;
      rel_q <= rel_d;
    end
  end

  assign evt_now = byte_vld ? evt_d : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_now;
  end

  assign ext_pend = ext_q;
  assign rel_pend = rel_q;
endmodule

// File: rtl/kbd_held_table.sv
module kbd_held_table
  import kbd_dec_pkg::*;
#(
  parameter int unsigned BANKS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  kbd_evt_t                        upd,
  input  logic [$clog2(BANKS)-1:0]        qry_bank,
  input  logic [KC_W-1:0]                 qry_code,
  output logic                            qry_held,
  output logic [BANKS-1:0][2**KC_W-1:0]   held_vec
);
  localparam int unsigned DEPTH = 2**KC_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DEPTH-1:0] bits_q, bits_d;
    logic             bank_en;

    assign bank_en = upd.vld && (32'(upd.ext) == b);

    always_comb begin
      bits_d = bits_q;
      bits_d[upd.code] = !upd.rel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bits_q <= '0;
      else if (bank_en) bits_q <= bits_d;
    end

    assign held_vec[b] = bits_q;
  end

  assign qry_held = held_vec[qry_bank][qry_code];
endmodule

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder
  import kbd_dec_pkg::*;
#(
  parameter logic [KC_W-1:0] EXT_PREFIX  = 8'hE0,
  parameter logic [KC_W-1:0] REL_PREFIX  = 8'hF0,
  parameter logic [KC_W-1:0] SHIFT_CODE  = 8'h12,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_vld,
  input  logic [KC_W-1:0] byte_data,
  output logic            evt_vld,
  output logic [KC_W-1:0] evt_code,
  output logic            evt_ext,
  output logic            evt_rel,
  input  logic            qry_ext,
  input  logic [KC_W-1:0] qry_code,
  output logic            qry_held
);
  logic                     srst_n;
  logic                     ext_pend, rel_pend;
  kbd_evt_t                 evt_now, evt_q;
  logic [1:0][2**KC_W-1:0]  held_vec;

  kbd_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  kbd_prefix_fsm #(
    .EXT_PREFIX(EXT_PREFIX), .REL_PREFIX(REL_PREFIX), .SHIFT_CODE(SHIFT_CODE)
  ) fsm_i (
    .clk(clk), .rst_n(srst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .ext_pend(ext_pend), .rel_pend(rel_pend), .evt_now(evt_now), .evt_q(evt_q)
  );

  kbd_held_table #(.BANKS(2)) tbl_i (
    .clk(clk), .rst_n(srst_n), .upd(evt_now),
    .qry_bank(qry_ext), .qry_code(qry_code),
    .qry_held(qry_held), .held_vec(held_vec)
  );

  assign evt_vld  = evt_q.vld;
  assign evt_code = evt_q.code;
  assign evt_ext  = evt_q.ext;
  assign evt_rel  = evt_q.rel;
endmodule

// File: rtl/kbd_event_decoder_chk.sv
module kbd_event_decoder_chk #(
  parameter logic [7:0] EXT_PREFIX = 8'hE0,
  parameter logic [7:0] REL_PREFIX = 8'hF0,
  parameter logic [7:0] SHIFT_CODE = 8'h12
) (
  input logic             clk,
  input logic             srst_n,
  input logic             byte_vld,
  input logic [7:0]       byte_data,
  input logic             evt_vld,
  input logic [7:0]       evt_code,
  input logic             evt_ext,
  input logic             evt_rel,
  input logic             ext_pend,
  input logic             rel_pend,
  input logic [1:0][255:0] held_vec
);
  logic is_pfx;
  assign is_pfx = (byte_data == EXT_PREFIX) || (byte_data == REL_PREFIX);

  p_evt_needs_byte_r10: assert property (@(posedge clk) disable iff (!srst_n)
    evt_vld |-> $past(byte_vld));

  p_prefix_silent_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (byte_vld && is_pfx) |=> !evt_vld);

  p_wrapper_silent_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (byte_vld && ext_pend && byte_data == SHIFT_CODE) |=> (!evt_vld && $stable(held_vec)));

  p_code_passes_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (byte_vld && !is_pfx && !(ext_pend && byte_data == SHIFT_CODE))
      |=> (evt_vld && evt_code == $past(byte_data) && evt_ext == $past(ext_pend)
           && evt_rel == $past(rel_pend)));

  p_press_sets_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (evt_vld && !evt_rel) |-> held_vec[evt_ext][evt_code]);

  p_release_clears_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (evt_vld && evt_rel) |-> !held_vec[evt_ext][evt_code]);

  p_prefix_cleared_r9: assert property (@(posedge clk) disable iff (!srst_n)
    evt_vld |-> (!ext_pend && !rel_pend));

  p_table_idle_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(byte_vld) |-> $stable(held_vec));
endmodule

bind kbd_event_decoder kbd_event_decoder_chk #(
  .EXT_PREFIX(EXT_PREFIX), .REL_PREFIX(REL_PREFIX), .SHIFT_CODE(SHIFT_CODE)
) chk_i (
  .clk(clk), .srst_n(srst_n), .byte_vld(byte_vld), .byte_data(byte_data),
  .evt_vld(evt_vld), .evt_code(evt_code), .evt_ext(evt_ext), .evt_rel(evt_rel),
  .ext_pend(ext_pend), .rel_pend(rel_pend), .held_vec(held_vec)
);

// File: tb/kbd_event_decoder_tb_top.sv
module kbd_event_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       qry_ext = 1'b0;
  logic [7:0] qry_code = 8'h00;
  logic       evt_vld, evt_ext, evt_rel, qry_held;
  logic [7:0] evt_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  kbd_event_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .evt_vld(evt_vld), .evt_code(evt_code), .evt_ext(evt_ext), .evt_rel(evt_rel),
    .qry_ext(qry_ext), .qry_code(qry_code), .qry_held(qry_held)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one byte per call; returns at the negedge where its event is visible
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(negedge clk);
    byte_vld  = 1'b0;
  endtask

  task automatic expect_evt(input logic [7:0] c, input bit x, input bit r, input string req);
    chk(evt_vld, 1, req);
    chk(evt_code, c, req);
    chk(evt_ext, x, req);
    chk(evt_rel, r, req);
  endtask

  task automatic held(input bit x, input logic [7:0] c, input bit exp, input string req);
    qry_ext  = x;
    qry_code = c;
    #1;
    chk(qry_held, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, full table scan
    chk(evt_vld, 0, "R1");
    for (int i = 0; i < 512; i++) held(i[8], i[7:0], 1'b0, "R1");

    // Sweep all codes through press/release in both banks
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      bit ext_ok;
      c = i[7:0];
      if (c == 8'hE0 || c == 8'hF0) continue;
      ext_ok = (c != 8'h12);
      send(c);
      expect_evt(c, 1'b0, 1'b0, "R2");
      held(1'b0, c, 1'b1, "R6");
      held(1'b1, c, 1'b0, "R6");
      @(negedge clk);
      chk(evt_vld, 0, "R10");
      if (ext_ok) begin
        send(8'hE0);
        chk(evt_vld, 0, "R4");
        send(c);
        expect_evt(c, 1'b1, 1'b0, "R4");
        held(1'b1, c, 1'b1, "R6");
      end
      send(8'hF0);
      chk(evt_vld, 0, "R3");
      send(c);
      expect_evt(c, 1'b0, 1'b1, "R3");
      held(1'b0, c, 1'b0, "R6");
      held(1'b1, c, ext_ok, "R6");
      if (ext_ok) begin
        send(8'hE0);
        send(8'hF0);
        chk(evt_vld, 0, "R4");
        send(c);
        expect_evt(c, 1'b1, 1'b1, "R4");
        held(1'b1, c, 1'b0, "R6");
      end
    end

    // R5: wrappers around an extended key while plain shift is held
    send(8'h12);
    expect_evt(8'h12, 1'b0, 1'b0, "R5");
    send(8'hE0); send(8'hF0); send(8'h12);
    chk(evt_vld, 0, "R5");
    held(1'b0, 8'h12, 1'b1, "R5");
    held(1'b1, 8'h12, 1'b0, "R5");
    send(8'hE0); send(8'h70);
    expect_evt(8'h70, 1'b1, 1'b0, "R5");
    send(8'hE0); send(8'hF0); send(8'h70);
    expect_evt(8'h70, 1'b1, 1'b1, "R5");
    send(8'hE0); send(8'h12);
    chk(evt_vld, 0, "R5");
    held(1'b0, 8'h12, 1'b1, "R5");
    // R9: discard clears prefix; next byte is a plain press
    send(8'h29);
    expect_evt(8'h29, 1'b0, 1'b0, "R9");
    send(8'hF0); send(8'h29);
    send(8'hF0); send(8'h12);
    expect_evt(8'h12, 1'b0, 1'b1, "R5");
    held(1'b0, 8'h12, 1'b0, "R5");

    // R7: overlapping keys
    send(8'h1C);
    send(8'h32);
    send(8'hE0); send(8'h75);
    held(1'b0, 8'h1C, 1'b1, "R7");
    held(1'b0, 8'h32, 1'b1, "R7");
    held(1'b1, 8'h75, 1'b1, "R7");
    send(8'hF0); send(8'h32);
    expect_evt(8'h32, 1'b0, 1'b1, "R7");
    held(1'b0, 8'h32, 1'b0, "R7");
    held(1'b0, 8'h1C, 1'b1, "R7");
    held(1'b1, 8'h75, 1'b1, "R7");

    // R8: release of a key never pressed
    send(8'hF0); send(8'h2B);
    expect_evt(8'h2B, 1'b0, 1'b1, "R8");
    held(1'b0, 8'h2B, 1'b0, "R8");
    held(1'b1, 8'h2B, 1'b0, "R8");
    held(1'b0, 8'h1C, 1'b1, "R8");
    held(1'b1, 8'h75, 1'b1, "R8");

    // R9: after extended release the next byte is plain
    send(8'hE0); send(8'hF0); send(8'h75);
    expect_evt(8'h75, 1'b1, 1'b1, "R9");
    send(8'h1C);
    expect_evt(8'h1C, 1'b0, 1'b0, "R9");

    // R10: idle gaps inside a sequence
    send(8'hE0);
    repeat (5) begin
      @(negedge clk);
      chk(evt_vld, 0, "R10");
    end
    send(8'hF0);
    repeat (3) @(negedge clk);
    send(8'h74);
    expect_evt(8'h74, 1'b1, 1'b1, "R10");
    @(negedge clk);
    chk(evt_vld, 0, "R10");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule